// File: doc/BRIEF.md
# Programmable SRAM Bus Cycle Controller

This block turns internal word requests into external bus cycles for one chip-select area of a local bus in asynchronous-SRAM mode. A requester presents an address, a write flag, four byte enables and a 32-bit write word. The block compares three upper address bits with a configured area code and ignores any request for another area. On a hit it drives an active-low chip select, a read strobe that can serve as output enable, four active-low byte write strobes, a bus-start strobe, the external address and the outgoing data.

The timing comes from configuration inputs. These set the address/select setup before the strobe, the hold after it, the number of access waits and a one-cycle bus-start stretch. An external ready pin can lengthen the strobe further. The external data path can be 8, 16 or 32 bits wide. A word access on a narrower bus becomes a run of bus cycles, lowest bytes first, and each of those cycles has its own setup, strobe and hold. For a read, the bytes gathered from each cycle are returned together with a one-cycle completion pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A request is taken only when `req_addr[28:26]` equals `cfg_area`. Any other request is ignored: the select and strobes stay high and no completion pulse appears.
- R2: `cfg_size` selects the bus width: 2'b00 = 8 bits on lane 0, 2'b01 = 16 bits on lanes 0-1, 2'b10 and 2'b11 = 32 bits. A word access takes 4, 2 or 1 bus cycles in little-endian order. Cycle b presents the word-aligned address plus b times the lane count.
- R3: `bus_cs_n` is low from the first setup cycle to the last hold cycle of every bus cycle. `bus_rd_n` is low only in the strobe phase of reads. `bus_we_n[l]` is low only in the strobe phase of writes, and only when lane l carries an enabled byte. Lane l means data bits [8l+7:8l].
- R4: With ready high, the strobe phase lasts 1 + min(`cfg_wait`, 25) cycles. Values above 25 act as 25.
- R5: When the effective wait count is nonzero, `bus_rdy` is sampled only on the last wait cycle of the strobe phase. While it is low there, the strobe grows by one cycle and ready is sampled again. On earlier cycles it has no effect. When the wait count is zero, ready is ignored.
- R6: The setup phase lasts `cfg_setup` cycles (0-7) and the hold phase lasts `cfg_hold` cycles (0-7). The address and outgoing data stay unchanged through the whole bus cycle.
- R7: `bus_bs_n` is low on the first strobe cycle of each bus cycle. When `cfg_bs_hold` is 1 and `cfg_setup` is at least 1, it is also low on the last setup cycle. Otherwise the stretch setting has no effect.
- R8: On writes, `bus_doe` is high for the whole bus cycle. Lane l of `bus_dout` carries write byte b*N+l for bus cycle b on an N-lane bus, and unused lanes are zero.
- R9: On reads, each bus cycle captures its lanes from `bus_din` on its last strobe cycle. After the final bus cycle, `rsp_done` pulses for exactly one cycle, and during that pulse `rsp_rdata` holds all four bytes in little-endian order.
- R10: After reset the select and all strobes are high, `rsp_done` is low and `req_ready` is high. While an access is in progress, `req_ready` is low and requests are ignored.
- R11: The configuration is captured when a request is taken. Configuration changes during an access do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Request byte address |
| req_be | input | 4 | Byte enables of the word |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | Idle, a request can be taken |
| cfg_area | input | 3 | Area code compared with address bits [28:26] |
| cfg_size | input | 2 | Bus width code |
| cfg_wait | input | 5 | Access wait count |
| cfg_setup | input | 3 | Setup cycles before the strobe |
| cfg_hold | input | 3 | Hold cycles after the strobe |
| cfg_bs_hold | input | 1 | Bus-start stretch into the setup phase |
| bus_rdy | input | 1 | External ready, high = ready |
| bus_din | input | 32 | External read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | 4 | Byte write strobes, active low, bit l = lane l |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_addr | output | 29 | External address, zero when idle |
| bus_dout | output | 32 | External write data |
| bus_doe | output | 1 | Write data drive enable |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read word, valid with the pulse |

## Verification
On every cycle, the assertions check these relations between the outputs:
- the strobes and the bus-start pulse only inside an active chip select;
- the read and write strobes never together;
- the address steady across a continuing read strobe;
- a completion pulse one cycle long that follows the end of a select;
- a select that starts only after a request was taken;
- a miss that leaves the block idle.

Exact phase lengths, wait clamping, the single ready sample point, lane mapping per width, the byte order of the read word and the capture of the configuration can only be shown by the bench scenarios. There, a behavioural model lays out the expected value of every output for every cycle and checks it.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    localparam int LANES    = 4;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = LANES * BYTE_W;
    localparam int WAIT_MAX = 25;
    localparam int CNT_W    = 5;
    localparam int AREA_W   = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [2:0]       setup;
        logic [2:0]       hold;
        logic [CNT_W-1:0] waits;
        logic             bs_hold;
        logic [1:0]       size;
    } timing_t;

    function automatic logic [CNT_W-1:0] clamp_wait(input logic [CNT_W-1:0] w);
        return (w > CNT_W'(WAIT_MAX)) ? CNT_W'(WAIT_MAX) : w;
    endfunction

    // log2 of the number of lanes used per bus cycle
    function automatic logic [1:0] width_shift(input logic [1:0] size);
        case (size)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [2:0] lane_count(input logic [1:0] size);
        return 3'd1 << width_shift(size);
    endfunction

    function automatic logic [1:0] last_beat(input logic [1:0] size);
        return 2'(3'(LANES) >> width_shift(size)) - 2'd1;
    endfunction

endpackage

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
    import sram_cyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t tcfg,
    input  logic    bus_rdy,
    output phase_e  phase,
    output logic [1:0] beat,
    output logic    strobe_end,
    output logic    bs_act,
    output logic    done
);

    logic [CNT_W-1:0] cnt;
    logic             first_q;
    logic             last;
    logic             beat_end;
    phase_e           entry_ph;
    logic [CNT_W-1:0] entry_cnt;

    always_comb begin
        last       = (beat == last_beat(tcfg.size));
        strobe_end = (phase == PH_STROBE) && (cnt == '0) &&
                     ((tcfg.waits == '0) || bus_rdy);
        beat_end   = ((phase == PH_HOLD) && (cnt == '0)) ||
                     (strobe_end && (tcfg.hold == 3'd0));
        if (tcfg.setup != 3'd0) begin
            entry_ph  = PH_SETUP;
            entry_cnt = CNT_W'(tcfg.setup - 3'd1);
        end else begin
            entry_ph  = PH_STROBE;
            entry_cnt = tcfg.waits;
        end
        bs_act = ((phase == PH_STROBE) && first_q) ||
                 ((phase == PH_SETUP) && (cnt == '0) && tcfg.bs_hold);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            beat    <= '0;
            first_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done    <= 1'b0;
            first_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= entry_ph;
                        cnt     <= entry_cnt;
                        beat    <= '0;
                        first_q <= (tcfg.setup == 3'd0);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase   <= PH_STROBE;
                        cnt     <= tcfg.waits;
                        first_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (strobe_end && (tcfg.hold != 3'd0)) begin
                        phase <= PH_HOLD;
                        cnt   <= CNT_W'(tcfg.hold - 3'd1);
                    end
                end
                PH_HOLD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
            if (beat_end) begin
                if (last) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else begin
                    beat    <= beat + 1'b1;
                    phase   <= entry_ph;
                    cnt     <= entry_cnt;
                    first_q <= (tcfg.setup == 3'd0);
                end
            end
        end
    end

endmodule

// File: rtl/sram_cyc_lanes.sv
module sram_cyc_lanes
    import sram_cyc_pkg::*;
#(
    parameter int ADDR_W = 29
) (
    input  logic [1:0]        size,
    input  logic [1:0]        beat,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  we_en,
    output logic [DATA_W-1:0] dout
);

    logic [1:0]        off;
    logic [LANES-1:0]  be_s;
    logic [DATA_W-1:0] wd_s;

    always_comb begin
        off  = beat << width_shift(size);
        be_s = be >> off;
        wd_s = wdata >> {off, 3'b000};
        addr = base + ADDR_W'(off);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic used;
        assign used = (3'(l) < lane_count(size));
        assign we_en[l] = used & be_s[l];
        assign dout[l*BYTE_W +: BYTE_W] = used ? wd_s[l*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/sram_cyc_rdmerge.sv
module sram_cyc_rdmerge
    import sram_cyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap,
    input  logic [1:0]        size,
    input  logic [1:0]        beat,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);

    logic [1:0] sh;
    logic [1:0] lane_mask;

    always_comb begin
        sh        = width_shift(size);
        lane_mask = 2'(lane_count(size) - 3'd1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        logic [BYTE_W-1:0] q;
        logic              own;
        logic [1:0]        lane;

        always_comb begin
            own  = ((2'(i) >> sh) == beat);
            lane = 2'(i) & lane_mask;
        end

        always_ff @(posedge clk) begin
            if (rst || clear) q <= '0;
            else if (cap && own) q <= din[lane*BYTE_W +: BYTE_W];
        end

        assign rdata[i*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_cyc_pkg::*;
#(
    parameter int ADDR_W   = 29,
    parameter int AREA_LSB = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [AREA_W-1:0] cfg_area,
    input  logic [1:0]        cfg_size,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [2:0]        cfg_setup,
    input  logic [2:0]        cfg_hold,
    input  logic              cfg_bs_hold,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [LANES-1:0]  bus_we_n,
    output logic              bus_bs_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LANES - 1);

    timing_t           live_cfg, tcfg_q, tcfg_use;
    logic              busy, hit, start;
    logic              wr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wd_q;
    logic [ADDR_W-1:0] base_q;
    phase_e            phase;
    logic [1:0]        beat;
    logic              strobe_end, bs_act, done;
    logic [ADDR_W-1:0] lane_addr;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_dout;
    logic              strobe;

    always_comb begin
        live_cfg.setup   = cfg_setup;
        live_cfg.hold    = cfg_hold;
        live_cfg.waits   = clamp_wait(cfg_wait);
        live_cfg.bs_hold = cfg_bs_hold;
        live_cfg.size    = cfg_size;
        busy      = (phase != PH_IDLE);
        hit       = (req_addr[AREA_LSB +: AREA_W] == cfg_area);
        start     = req_valid && !busy && hit;
        tcfg_use  = busy ? tcfg_q : live_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcfg_q <= '0;
            wr_q   <= 1'b0;
            be_q   <= '0;
            wd_q   <= '0;
            base_q <= '0;
        end else if (start) begin
            tcfg_q <= live_cfg;
            wr_q   <= req_write;
            be_q   <= req_be;
            wd_q   <= req_wdata;
            base_q <= req_addr & ALIGN_MASK;
        end
    end

    sram_cyc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tcfg       (tcfg_use),
        .bus_rdy    (bus_rdy),
        .phase      (phase),
        .beat       (beat),
        .strobe_end (strobe_end),
        .bs_act     (bs_act),
        .done       (done)
    );

    sram_cyc_lanes #(.ADDR_W(ADDR_W)) u_lanes (
        .size  (tcfg_q.size),
        .beat  (beat),
        .be    (be_q),
        .wdata (wd_q),
        .base  (base_q),
        .addr  (lane_addr),
        .we_en (lane_we),
        .dout  (lane_dout)
    );

    sram_cyc_rdmerge u_rd (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .cap   (strobe_end && !wr_q),
        .size  (tcfg_q.size),
        .beat  (beat),
        .din   (bus_din),
        .rdata (rsp_rdata)
    );

    always_comb begin
        strobe    = (phase == PH_STROBE);
        req_ready = !busy;
        bus_cs_n  = !busy;
        bus_rd_n  = !(strobe && !wr_q);
        bus_we_n  = ~({LANES{strobe && wr_q}} & lane_we);
        bus_bs_n  = !bs_act;
        bus_addr  = busy ? lane_addr : '0;
        bus_doe   = busy && wr_q;
        bus_dout  = bus_doe ? lane_dout : '0;
        rsp_done  = done;
    end

endmodule

// File: rtl/sram_cyc_chk.sv
module sram_cyc_chk #(
    parameter int ADDR_W = 29
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_area,
    input logic [2:0]        cfg_area,
    input logic              req_ready,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic [3:0]        bus_we_n,
    input logic              bus_bs_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_doe,
    input logic              rsp_done
);

    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || (bus_we_n != 4'hF)) |-> !bus_cs_n);

    a_r3_rd_we_excl: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> (bus_we_n == 4'hF));

    a_r3_cs_after_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_cs_n) |-> $past(req_valid && req_ready));

    a_r7_bs_in_cs: assert property (@(posedge clk) disable iff (rst)
        !bus_bs_n |-> !bus_cs_n);

    a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n && $past(!bus_rd_n) && bus_bs_n) |-> $stable(bus_addr));

    a_r8_doe_in_cs: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> !bus_cs_n);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r9_done_after_cs: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (bus_cs_n && $past(!bus_cs_n)));

    a_r1_miss_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && (req_area != cfg_area)) |=> req_ready);

endmodule

bind sram_cycle_ctrl sram_cyc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_area  (req_addr[AREA_LSB +: 3]),
    .cfg_area  (cfg_area),
    .req_ready (req_ready),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_we_n  (bus_we_n),
    .bus_bs_n  (bus_bs_n),
    .bus_addr  (bus_addr),
    .bus_doe   (bus_doe),
    .rsp_done  (rsp_done)
);

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [28:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [2:0]  cfg_area = 3'b100;
    logic [1:0]  cfg_size = 2'b10;
    logic [4:0]  cfg_wait = '0;
    logic [2:0]  cfg_setup = '0, cfg_hold = '0;
    logic        cfg_bs_hold = 1'b0;
    logic        bus_rdy = 1'b1;
    logic [31:0] bus_din;
    logic        bus_cs_n, bus_rd_n, bus_bs_n, bus_doe, rsp_done;
    logic [3:0]  bus_we_n;
    logic [28:0] bus_addr;
    logic [31:0] bus_dout, rsp_rdata;

    always #5 clk = ~clk;

    sram_cycle_ctrl u_dut (.*);

    function automatic logic [7:0] mbyte(input logic [28:0] a);
        return a[7:0] ^ 8'h5A ^ {a[9:8], 6'b0};
    endfunction

    assign bus_din = {mbyte(bus_addr + 29'd3), mbyte(bus_addr + 29'd2),
                      mbyte(bus_addr + 29'd1), mbyte(bus_addr)};

    typedef struct {
        bit          cs_n, rd_n, bs_n, doe, done, chk_rd, rdy, rr;
        logic [3:0]  we_n;
        logic [28:0] addr;
        logic [31:0] dout, rdata;
    } exp_t;

    exp_t  q[$];
    int    total = 0, bad = 0, cyc = 0;
    string scen = "R10 reset";

    function automatic exp_t mk(bit cs_n, bit rd_n, logic [3:0] we_n, bit bs_n,
                                logic [28:0] addr, bit doe, logic [31:0] dout, bit rdy);
        exp_t e;
        e.cs_n = cs_n; e.rd_n = rd_n; e.we_n = we_n; e.bs_n = bs_n;
        e.addr = addr; e.doe = doe; e.dout = dout; e.rdy = rdy;
        e.done = 1'b0; e.chk_rd = 1'b0; e.rdata = '0; e.rr = 1'b0;
        return e;
    endfunction

    function automatic exp_t idle_e();
        exp_t e = mk(1, 1, 4'hF, 1, '0, 0, '0, 1);
        e.rr = 1'b1;
        return e;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] act=%h exp=%h cycle=%0d", what, scen, act, exp, cyc);
        end
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        cyc++;
        e = (q.size() > 0) ? q.pop_front() : idle_e();
        bus_rdy = e.rdy;
        chk(bus_cs_n == e.cs_n, "R3 cs_n", 32'(bus_cs_n), 32'(e.cs_n));
        chk(bus_rd_n == e.rd_n, "R3 rd_n", 32'(bus_rd_n), 32'(e.rd_n));
        chk(bus_we_n == e.we_n, "R3 we_n", 32'(bus_we_n), 32'(e.we_n));
        chk(bus_bs_n == e.bs_n, "R7 bs_n", 32'(bus_bs_n), 32'(e.bs_n));
        chk(bus_addr == e.addr, "R2/R6 addr", 32'(bus_addr), 32'(e.addr));
        chk(bus_doe == e.doe, "R8 doe", 32'(bus_doe), 32'(e.doe));
        if (e.doe) chk(bus_dout == e.dout, "R8 dout", bus_dout, e.dout);
        chk(rsp_done == e.done, "R9 done", 32'(rsp_done), 32'(e.done));
        if (e.chk_rd) chk(rsp_rdata == e.rdata, "R9 rdata", rsp_rdata, e.rdata);
        chk(req_ready == e.rr, "R10 ready", 32'(req_ready), 32'(e.rr));
    endtask

    task automatic build(input bit wr, input logic [28:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input logic [1:0] sz, input int su,
                         input int ho, input int wt, input bit bsh, input int k);
        int n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        int w = (wt > 25) ? 25 : wt;
        int kk = (w > 0) ? k : 0;
        logic [28:0] base = a & ~29'h3;
        exp_t e;
        for (int b = 0; b < 4 / n; b++) begin
            logic [28:0] ad = base + 29'(b * n);
            logic [3:0]  we = 4'hF;
            logic [31:0] dv = '0;
            for (int l = 0; l < n; l++) begin
                if (wr && be[b*n+l]) we[l] = 1'b0;
                dv[l*8 +: 8] = wd[(b*n+l)*8 +: 8];
            end
            for (int s = 0; s < su; s++)
                q.push_back(mk(0, 1, 4'hF, !(bsh && s == su - 1), ad, wr, dv, 1));
            for (int j = 0; j < 1 + w + kk; j++)
                q.push_back(mk(0, wr, wr ? we : 4'hF, j != 0, ad, wr, dv,
                               (w == 0) ? 1'b0 : (j >= w + kk)));
            for (int h = 0; h < ho; h++)
                q.push_back(mk(0, 1, 4'hF, 1, ad, wr, dv, 1));
        end
        e = idle_e();
        e.done = 1'b1;
        if (!wr) begin
            e.chk_rd = 1'b1;
            e.rdata = {mbyte(base + 29'd3), mbyte(base + 29'd2),
                       mbyte(base + 29'd1), mbyte(base)};
        end
        q.push_back(e);
    endtask

    task automatic txn(input bit wr, input logic [28:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [1:0] sz, input int su,
                       input int ho, input int wt, input bit bsh, input int k,
                       input bit poke);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        cfg_size = sz; cfg_setup = 3'(su); cfg_hold = 3'(ho); cfg_wait = 5'(wt);
        cfg_bs_hold = bsh;
        build(wr, a, be, wd, sz, su, ho, wt, bsh, k);
        step();
        if (poke) begin
            req_addr = a ^ 29'h4; req_write = !wr; req_wdata = ~wd;
            cfg_setup = 3'(su + 1); cfg_hold = 3'd0; cfg_wait = 5'd0; cfg_size = 2'b00;
        end else begin
            req_valid = 1'b0;
        end
        while (q.size() > 0) step();
        req_valid = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired [%s]", scen);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        scen = "R10 reset state";
        repeat (3) step();
        rst = 1'b0;
        step();

        scen = "R2 R3 R8 32-bit write, no waits";
        txn(1, 29'h1000_0010, 4'hF, 32'hA1B2C3D4, 2'b10, 0, 0, 0, 0, 0, 0);
        scen = "R4 R6 R9 32-bit read setup2 hold1 wait3";
        txn(0, 29'h1000_0124, 4'hF, '0, 2'b10, 2, 1, 3, 0, 0, 0);
        scen = "R2 R7 R3 16-bit partial write with bs stretch";
        txn(1, 29'h1000_0200, 4'b1010, 32'h11223344, 2'b01, 1, 2, 1, 1, 0, 0);
        scen = "R5 R9 8-bit read ready extension";
        txn(0, 29'h1000_0331, 4'hF, '0, 2'b00, 0, 1, 2, 0, 3, 0);
        scen = "R5 wait0 ready ignored 8-bit write";
        txn(1, 29'h1000_0040, 4'b0110, 32'hDEADBEEF, 2'b00, 1, 0, 0, 0, 2, 0);
        scen = "R4 wait clamp 31->25 with R5 extension";
        txn(0, 29'h1000_0400, 4'hF, '0, 2'b10, 0, 0, 31, 0, 1, 0);
        scen = "R7 stretch ignored when setup is zero";
        txn(0, 29'h1000_0008, 4'hF, '0, 2'b01, 0, 0, 1, 1, 0, 0);
        scen = "R2 size 11 acts as 32-bit";
        txn(1, 29'h1000_0050, 4'b1001, 32'h55667788, 2'b11, 0, 1, 0, 0, 0, 0);
        scen = "R6 setup7 hold7 16-bit read";
        txn(0, 29'h1000_0566, 4'hF, '0, 2'b01, 7, 7, 0, 1, 0, 0);
        scen = "R10 R11 busy requests and config changes ignored";
        txn(1, 29'h1000_0600, 4'hF, 32'hCAFE0123, 2'b01, 2, 1, 2, 1, 1, 1);

        scen = "R1 miss ignored";
        req_valid = 1'b1; req_write = 1'b1; req_addr = 29'h0C00_0000; req_be = 4'hF;
        repeat (4) step();
        req_valid = 1'b0;
        step();
        scen = "R1 other area code hit";
        cfg_area = 3'b011;
        txn(0, 29'h0C00_0040, 4'hF, '0, 2'b10, 1, 0, 0, 0, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule